// File: doc/BRIEF.md
# Auto-Initialising Audio DMA Channel

This block is a single bus-master DMA channel that moves audio sample frames between a circular buffer in memory and a sample stream. Software programs a buffer start address, a frame count and a mode word (direction, sample width, channel count, byte order, signedness), then enables the channel. In playback the channel reads one memory word per frame, decodes it into a left/right pair of 16-bit samples and offers the pair on a valid/ready stream. In capture it accepts sample pairs from a stream, encodes them in the chosen format and writes them back with byte enables.

The buffer is walked frame by frame. When the last frame is done the channel either stops or, with auto-restart selected, reloads its address and count from the programmed registers and carries on. A mask bit pauses the channel at a frame boundary without losing its place. Events at the halfway point and at the end of the buffer can each be enabled, are latched in a status word that clears when read, and drive an interrupt line that a separate end-of-service write re-arms.

Top module: `audio_dma_chan`

## Requirements
- R1: Register word index on `reg_addr`: 0 start address, 1 frame count, 2 current address (read only), 3 mode, 4 control, 5 status (read only), 6 end-of-service (write only); read data appears on `reg_rdata` one cycle after `reg_rd_en`.
- R2: Mode bits: bit0 capture (0 playback), bit1 enable, bit2 auto-restart, bit3 8-bit samples, bit4 mono, bit5 big-endian, bit6 unsigned; control bits: bit0 mask, bit1 halfway event enable, bit2 end event enable; status bits: bit0 halfway, bit1 end.
- R3: A frame count value C moves exactly C+1 frames; the current address advances by the frame size in bytes, which is 1 or 2 for 8 or 16-bit samples, doubled for stereo; a frame never straddles a 32-bit word.
- R4: Playback decoding: 16-bit samples are little-endian in memory unless big-endian is set; 8-bit samples go to the upper byte of the 16-bit output with a zero lower byte; stereo frames put the first sample on the left lane, mono frames copy one sample to both lanes.
- R5: In unsigned mode the most significant bit of every 16-bit sample is inverted, on both the playback and the capture path.
- R6: Capture encoding is the inverse of R4 (8-bit mode stores the upper byte, mono stores the left lane only); only the frame's own bytes are written, all other bytes keep their contents.
- R7: Without auto-restart the channel stops after the last frame; with auto-restart it reloads the address from the start register and the count from the count register and continues with no software action.
- R8: While the mask bit is set no new frame is started; a frame already started completes; clearing the mask resumes at the next frame in sequence.
- R9: Writes to the start and count registers during a transfer do not move the current address; they are used at the next enable or auto-restart.
- R10: With N = C+1 frames, the halfway event fires when floor(N/2) frames of the pass have completed (never for N = 1) and the end event when the last frame completes; each sets its status bit only if its enable bit is set.
- R11: Reading the status register clears it.
- R12: The interrupt output rises when a status bit is pending and the line is armed, falls after the status is cleared, stays low for new events until an end-of-service write re-arms it.
- R13: A memory request holds its address until granted, and an offered sample pair holds until accepted.
- R14: After reset the control register reads 1 (masked), status and current address read 0, and the interrupt, memory request and output valid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | Access is a write |
| mem_addr | output | AW-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_gnt | input | 1 | Access granted and completed this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| out_valid | output | 1 | Playback sample pair valid |
| out_ready | input | 1 | Playback sink ready |
| out_left | output | 16 | Playback left sample |
| out_right | output | 16 | Playback right sample |
| in_valid | input | 1 | Capture sample pair valid |
| in_ready | output | 1 | Channel ready for a capture pair |
| in_left | input | 16 | Capture left sample |
| in_right | input | 16 | Capture right sample |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the ones in the middle of a buffer pass: the halfway event with the end event still pending, the paused channel holding a half-finished position, and an auto-restart that picks up a start address written during the pause. The bench reaches them by rationing how many sample pairs its sink accepts, so the channel stalls after a chosen number of completed frames; it then reads status, toggles the mask and rewrites registers at that exact point. Formats are swept over all sixteen combinations in both directions with several grant latencies.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam logic [2:0] RA_BASE  = 3'd0;
  localparam logic [2:0] RA_COUNT = 3'd1;
  localparam logic [2:0] RA_CUR   = 3'd2;
  localparam logic [2:0] RA_MODE  = 3'd3;
  localparam logic [2:0] RA_CTRL  = 3'd4;
  localparam logic [2:0] RA_STAT  = 3'd5;
  localparam logic [2:0] RA_EOS   = 3'd6;

  // packed MSB first: rec lands on bit 0
  typedef struct packed {
    logic uns;
    logic big;
    logic mono;
    logic size8;
    logic autoinit;
    logic en;
    logic rec;
  } mode_t;

  typedef struct packed {
    logic term_ie;
    logic half_ie;
    logic mask;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_SEND,
    S_TAKE,
    S_STORE
  } eng_state_t;

  function automatic logic [2:0] frame_bytes(input mode_t m);
    if (m.size8) return m.mono ? 3'd1 : 3'd2;
    return m.mono ? 3'd2 : 3'd4;
  endfunction

endpackage

// File: rtl/dma_unpack.sv
module dma_unpack
  import dma_chan_pkg::*;
(
  input  logic [31:0] word,
  input  logic [1:0]  off,
  input  mode_t       mode,
  output logic [15:0] left,
  output logic [15:0] right
);

  function automatic logic [7:0] lane(input logic [31:0] w, input logic [1:0] i);
    return w[{i, 3'b000} +: 8];
  endfunction

  logic [1:0] o1, o2, o3;
  logic [15:0] s0, s1;

  assign o1 = off + 2'd1;
  assign o2 = off + 2'd2;
  assign o3 = off + 2'd3;

  always_comb begin
    s0 = mode.big ? {lane(word, off), lane(word, o1)} : {lane(word, o1), lane(word, off)};
    s1 = mode.big ? {lane(word, o2),  lane(word, o3)} : {lane(word, o3), lane(word, o2)};
    if (mode.size8) begin
      left  = {lane(word, off), 8'h00};
      right = mode.mono ? {lane(word, off), 8'h00} : {lane(word, o1), 8'h00};
    end else begin
      left  = s0;
      right = mode.mono ? s0 : s1;
    end
    if (mode.uns) begin
      left[15]  = ~left[15];
      right[15] = ~right[15];
    end
  end

endmodule

// File: rtl/dma_pack.sv
module dma_pack
  import dma_chan_pkg::*;
(
  input  logic [15:0] left,
  input  logic [15:0] right,
  input  logic [1:0]  off,
  input  mode_t       mode,
  output logic [31:0] wdata,
  output logic [3:0]  be
);

  logic [15:0] l2, r2;
  logic [7:0]  fb [4];
  logic [2:0]  nbytes;
  logic [1:0]  ln;

  assign nbytes = frame_bytes(mode);

  always_comb begin
    l2 = left;
    r2 = right;
    if (mode.uns) begin
      l2[15] = ~l2[15];
      r2[15] = ~r2[15];
    end
    if (mode.size8) begin
      fb[0] = l2[15:8];
      fb[1] = r2[15:8];
      fb[2] = 8'h00;
      fb[3] = 8'h00;
    end else if (mode.big) begin
      fb[0] = l2[15:8];
      fb[1] = l2[7:0];
      fb[2] = r2[15:8];
      fb[3] = r2[7:0];
    end else begin
      fb[0] = l2[7:0];
      fb[1] = l2[15:8];
      fb[2] = r2[7:0];
      fb[3] = r2[15:8];
    end
  end

  always_comb begin
    wdata = '0;
    be    = '0;
    ln    = off;
    for (int i = 0; i < 4; i++) begin
      ln = off + 2'(i);
      if (3'(i) < nbytes) begin
        wdata[{ln, 3'b000} +: 8] = fb[i];
        be[ln] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [AW-1:0] cur,
  input  logic          ev_half,
  input  logic          ev_term,
  output logic [AW-1:0] base,
  output logic [CW-1:0] count,
  output mode_t         mode,
  output ctrl_t         ctrl,
  output logic          start,
  output logic          irq
);

  logic [1:0] stat_q, stat_nx;
  logic       armed_q;
  logic       rd_clr;

  assign rd_clr  = rd_en && (addr == RA_STAT);
  assign stat_nx = (rd_clr ? 2'b00 : stat_q) |
                   {ev_term && ctrl.term_ie, ev_half && ctrl.half_ie};

  always_ff @(posedge clk) begin
    if (rst) begin
      base    <= '0;
      count   <= '0;
      mode    <= '0;
      ctrl    <= 3'b001;
      start   <= 1'b0;
      stat_q  <= '0;
      armed_q <= 1'b1;
      irq     <= 1'b0;
      rdata   <= '0;
    end else begin
      start  <= 1'b0;
      stat_q <= stat_nx;
      if (wr_en) begin
        case (addr)
          RA_BASE:  base  <= wdata[AW-1:0];
          RA_COUNT: count <= wdata[CW-1:0];
          RA_MODE: begin
            mode  <= mode_t'(wdata[6:0]);
            start <= wdata[1] && !mode.en;
          end
          RA_CTRL:  ctrl  <= ctrl_t'(wdata[2:0]);
          default: ;
        endcase
      end
      if (rd_en) begin
        case (addr)
          RA_BASE:  rdata <= 32'(base);
          RA_COUNT: rdata <= 32'(count);
          RA_CUR:   rdata <= 32'(cur);
          RA_MODE:  rdata <= 32'(mode);
          RA_CTRL:  rdata <= 32'(ctrl);
          RA_STAT:  rdata <= 32'(stat_q);
          default:  rdata <= '0;
        endcase
      end
      if (irq) begin
        irq <= |stat_q;
      end else if (armed_q && |stat_q) begin
        irq     <= 1'b1;
        armed_q <= 1'b0;
      end
      if (wr_en && addr == RA_EOS) armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  input  mode_t         mode,
  input  ctrl_t         ctrl,
  input  logic          start,
  output logic          mem_req,
  output logic          mem_wr,
  output logic [AW-3:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_l,
  output logic [15:0]   out_r,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_l,
  input  logic [15:0]   in_r,
  output logic [AW-1:0] cur,
  output logic          ev_half,
  output logic          ev_term
);

  localparam int TW = CW + 1;

  function automatic logic [TW-1:0] half_of(input logic [CW-1:0] c);
    logic [TW-1:0] n;
    n = TW'(c) + TW'(1);
    return n - (n >> 1);
  endfunction

  eng_state_t    st_q;
  logic [CW-1:0] rem_q, rem_nx;
  logic [TW-1:0] thr_q, thr_nx;
  logic [AW-1:0] cur_nx;
  logic          run_q, run_nx, pend_q;
  logic          last, mid;
  logic [2:0]    bpf;
  logic [15:0]   unp_l, unp_r;
  logic [31:0]   pk_w;
  logic [3:0]    pk_be;

  dma_unpack u_unpack (
    .word (mem_rdata),
    .off  (cur[1:0]),
    .mode (mode),
    .left (unp_l),
    .right(unp_r)
  );

  dma_pack u_pack (
    .left (in_l),
    .right(in_r),
    .off  (cur[1:0]),
    .mode (mode),
    .wdata(pk_w),
    .be   (pk_be)
  );

  assign bpf      = frame_bytes(mode);
  assign last     = (rem_q == '0);
  assign mid      = (TW'(rem_q) == thr_q);
  assign in_ready = (st_q == S_TAKE);

  always_comb begin
    cur_nx = cur + AW'(bpf);
    rem_nx = rem_q - CW'(1);
    thr_nx = thr_q;
    run_nx = run_q;
    if (last) begin
      if (mode.autoinit) begin
        cur_nx = base;
        rem_nx = count;
        thr_nx = half_of(count);
      end else begin
        rem_nx = rem_q;
        run_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      cur       <= '0;
      rem_q     <= '0;
      thr_q     <= '0;
      run_q     <= 1'b0;
      pend_q    <= 1'b0;
      mem_req   <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
      ev_half   <= 1'b0;
      ev_term   <= 1'b0;
    end else begin
      ev_half <= 1'b0;
      ev_term <= 1'b0;
      if (start) pend_q <= 1'b1;
      case (st_q)
        S_IDLE: begin
          if (pend_q) begin
            cur    <= base;
            rem_q  <= count;
            thr_q  <= half_of(count);
            run_q  <= 1'b1;
            pend_q <= start;
          end else if (!mode.en) begin
            run_q <= 1'b0;
          end else if (run_q && !ctrl.mask) begin
            if (mode.rec) begin
              st_q <= S_TAKE;
            end else begin
              mem_req  <= 1'b1;
              mem_wr   <= 1'b0;
              mem_addr <= cur[AW-1:2];
              st_q     <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (mem_gnt) begin
            mem_req   <= 1'b0;
            out_l     <= unp_l;
            out_r     <= unp_r;
            out_valid <= 1'b1;
            cur       <= cur_nx;
            rem_q     <= rem_nx;
            thr_q     <= thr_nx;
            run_q     <= run_nx;
            ev_half   <= mid;
            ev_term   <= last;
            st_q      <= S_SEND;
          end
        end
        S_SEND: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            st_q      <= S_IDLE;
          end
        end
        S_TAKE: begin
          if (in_valid) begin
            mem_wdata <= pk_w;
            mem_be    <= pk_be;
            mem_addr  <= cur[AW-1:2];
            mem_req   <= 1'b1;
            mem_wr    <= 1'b1;
            st_q      <= S_STORE;
          end
        end
        S_STORE: begin
          if (mem_gnt) begin
            mem_req <= 1'b0;
            mem_wr  <= 1'b0;
            cur     <= cur_nx;
            rem_q   <= rem_nx;
            thr_q   <= thr_nx;
            run_q   <= run_nx;
            ev_half <= mid;
            ev_term <= last;
            st_q    <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/audio_dma_chan.sv
module audio_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_en,
  input  logic          reg_rd_en,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_wr,
  output logic [AW-3:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_left,
  output logic [15:0]   out_right,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_left,
  input  logic [15:0]   in_right,
  output logic          irq
);

  logic [AW-1:0] base_w, cur_w;
  logic [CW-1:0] count_w;
  mode_t         mode_w;
  ctrl_t         ctrl_w;
  logic          start_w, ev_half_w, ev_term_w;
  logic          mask_w;

  assign mask_w = ctrl_w.mask;

  dma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr_en),
    .rd_en  (reg_rd_en),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .cur    (cur_w),
    .ev_half(ev_half_w),
    .ev_term(ev_term_w),
    .base   (base_w),
    .count  (count_w),
    .mode   (mode_w),
    .ctrl   (ctrl_w),
    .start  (start_w),
    .irq    (irq)
  );

  dma_engine #(.AW(AW), .CW(CW)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .base     (base_w),
    .count    (count_w),
    .mode     (mode_w),
    .ctrl     (ctrl_w),
    .start    (start_w),
    .mem_req  (mem_req),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_be   (mem_be),
    .mem_gnt  (mem_gnt),
    .mem_rdata(mem_rdata),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_l    (out_left),
    .out_r    (out_right),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_l     (in_left),
    .in_r     (in_right),
    .cur      (cur_w),
    .ev_half  (ev_half_w),
    .ev_term  (ev_term_w)
  );

endmodule

// File: rtl/audio_dma_chan_chk.sv
module audio_dma_chan_chk #(
  parameter int AW = 32
)(
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_wr,
  input logic          mem_gnt,
  input logic [AW-3:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          out_valid,
  input logic          out_ready,
  input logic [15:0]   out_left,
  input logic [15:0]   out_right,
  input logic          in_ready,
  input logic          reg_rd_en,
  input logic [2:0]    reg_addr,
  input logic          irq,
  input logic          mask
);

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  // R13
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_right));

  // R8
  no_fetch_masked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) && !mem_wr |-> !$past(mask));

  // R12
  irq_fall_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(reg_rd_en && reg_addr == 3'd5, 2));

  // R6
  be_frame_size_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_wr |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                           $countones(mem_be) == 4));

  // R3
  one_direction_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

endmodule

bind audio_dma_chan audio_dma_chan_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_req  (mem_req),
  .mem_wr   (mem_wr),
  .mem_gnt  (mem_gnt),
  .mem_addr (mem_addr),
  .mem_be   (mem_be),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_left (out_left),
  .out_right(out_right),
  .in_ready (in_ready),
  .reg_rd_en(reg_rd_en),
  .reg_addr (reg_addr),
  .irq      (irq),
  .mask     (mask_w)
);

// File: tb/audio_dma_chan_bench.sv
module audio_dma_chan_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_wr, mem_gnt = 1'b0;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        out_valid, out_ready, in_valid, in_ready, irq;
  logic [15:0] out_left, out_right, in_left, in_right;

  int tests = 0, fails = 0, lat = 0, wc = 0, allow = 0, ncap = 0, nsent = 0;
  bit done = 0;
  logic [7:0]  mb [256];
  logic [15:0] capl [512];
  logic [15:0] capr [512];

  always #5 clk = ~clk;

  audio_dma_chan u_audio_dma_chan (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .irq(irq)
  );

  function automatic logic [15:0] gen_l(input int i);
    return 16'h1357 + 16'(i * 16'h0931);
  endfunction
  function automatic logic [15:0] gen_r(input int i);
    return 16'hC0DE ^ 16'(i * 16'h0777);
  endfunction

  assign mem_rdata = {mb[{mem_addr[5:0], 2'd3}], mb[{mem_addr[5:0], 2'd2}],
                      mb[{mem_addr[5:0], 2'd1}], mb[{mem_addr[5:0], 2'd0}]};
  assign out_ready = (ncap < allow);
  assign in_valid  = 1'b1;
  assign in_left   = gen_l(nsent);
  assign in_right  = gen_r(nsent);

  always @(negedge clk) begin
    if (mem_req && !mem_gnt) begin
      if (wc >= lat) mem_gnt = 1'b1;
      else wc = wc + 1;
    end else begin
      mem_gnt = 1'b0;
      wc = 0;
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_wr)
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mb[{mem_addr[5:0], 2'(i)}] = mem_wdata[8*i +: 8];
  end

  always @(posedge clk) begin
    if (out_valid && out_ready) begin
      capl[ncap % 512] <= out_left;
      capr[ncap % 512] <= out_right;
      ncap <= ncap + 1;
    end
    if (in_valid && in_ready) nsent <= nsent + 1;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_cap(input int target);
    for (int t = 0; t < 3000 && ncap < target; t++) @(negedge clk);
  endtask

  task automatic start(input int b, input int n, input logic [31:0] ctl, input logic [31:0] md);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'(b));
    wr(3'd1, 32'(n - 1));
    wr(3'd4, ctl);
    wr(3'd3, md);
  endtask

  // fmt bits: 0 size8, 1 mono, 2 big-endian, 3 unsigned
  function automatic int bpf_of(input int f);
    return (f[0] ? 1 : 2) * (f[1] ? 1 : 2);
  endfunction

  function automatic logic [31:0] exp_play(input int a, input int f);
    logic [15:0] l, r;
    if (f[0]) begin
      l = {mb[8'(a)], 8'h00};
      r = f[1] ? l : {mb[8'(a + 1)], 8'h00};
    end else begin
      l = f[2] ? {mb[8'(a)], mb[8'(a + 1)]} : {mb[8'(a + 1)], mb[8'(a)]};
      r = f[1] ? l : (f[2] ? {mb[8'(a + 2)], mb[8'(a + 3)]} : {mb[8'(a + 3)], mb[8'(a + 2)]});
    end
    if (f[3]) begin l[15] = ~l[15]; r[15] = ~r[15]; end
    return {l, r};
  endfunction

  function automatic logic [7:0] exp_rec(input int idx, input int i, input int f);
    logic [15:0] l, r;
    logic [7:0]  fb [4];
    l = gen_l(idx); r = gen_r(idx);
    if (f[3]) begin l[15] = ~l[15]; r[15] = ~r[15]; end
    if (f[0]) begin fb[0] = l[15:8]; fb[1] = r[15:8]; fb[2] = 0; fb[3] = 0; end
    else if (f[2]) begin fb[0] = l[15:8]; fb[1] = l[7:0]; fb[2] = r[15:8]; fb[3] = r[7:0]; end
    else begin fb[0] = l[7:0]; fb[1] = l[15:8]; fb[2] = r[7:0]; fb[3] = r[15:8]; end
    return fb[i];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R13 watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c0, s0, b, n, bp;
    for (int i = 0; i < 256; i++) mb[i] = 8'(i * 37 + 11);
    tick(4);
    rst = 1'b0;
    tick(2);

    // R14 reset state
    check("R14 irq", 32'(irq), 0);
    check("R14 mem_req", 32'(mem_req), 0);
    check("R14 out_valid", 32'(out_valid), 0);
    rd(3'd4, d); check("R14 ctrl masked", d, 1);
    rd(3'd5, d); check("R14 status", d, 0);
    rd(3'd2, d); check("R14 cur", d, 0);
    wr(3'd0, 32'h1234); rd(3'd0, d); check("R1 base readback", d, 32'h1234);

    // R3 R4 R5 R7 playback sweep over all formats
    for (int f = 0; f < 16; f++) begin
      lat = f % 3; b = 8'h40; n = 5; bp = bpf_of(f);
      c0 = ncap; allow = c0 + n;
      start(b, n, 32'h6, 32'((f << 3) | 2));
      wait_cap(c0 + n);
      tick(20);
      check("R7 stops after last frame", 32'(ncap), 32'(c0 + n));
      for (int k = 0; k < n; k++)
        check($sformatf("R4 R5 play fmt %0d frame %0d", f, k),
              {capl[(c0 + k) % 512], capr[(c0 + k) % 512]}, exp_play(b + k * bp, f));
      rd(3'd5, d); check("R10 status half+end", d, 3);
      rd(3'd5, d); check("R11 status cleared", d, 0);
      rd(3'd2, d); check("R3 cur after pass", d, 32'(b + n * bp));
      wr(3'd6, 0);
    end

    // R6 R5 capture sweep
    for (int f = 0; f < 16; f++) begin
      lat = (f + 1) % 3; b = 8'h80; n = 4; bp = bpf_of(f);
      for (int i = 8'h80; i < 8'hC0; i++) mb[i] = 8'hEE;
      s0 = nsent;
      start(b, n, 32'h6, 32'((f << 3) | 3));
      for (int t = 0; t < 3000 && nsent < s0 + n; t++) @(negedge clk);
      tick(12);
      check("R7 capture count", 32'(nsent), 32'(s0 + n));
      for (int k = 0; k < n; k++)
        for (int i = 0; i < bp; i++)
          check($sformatf("R6 R5 rec fmt %0d frame %0d byte %0d", f, k, i),
                32'(mb[8'(b + k * bp + i)]), 32'(exp_rec(s0 + k, i, f)));
      check("R6 byte past buffer untouched", 32'(mb[8'(b + n * bp)]), 32'hEE);
      rd(3'd5, d); check("R10 capture status", d, 3);
      wr(3'd6, 0);
    end

    // R10 R12 halfway event and interrupt re-arm
    lat = 1; c0 = ncap; allow = c0 + 3;
    start(0, 8, 32'h6, 32'h2);
    tick(60);
    check("R12 irq raised on half", 32'(irq), 1);
    rd(3'd5, d); check("R10 half only at 4 of 8", d, 1);
    tick(3);
    check("R12 irq low after read", 32'(irq), 0);
    allow = c0 + 7;
    tick(60);
    check("R12 irq stays low before re-arm", 32'(irq), 0);
    wr(3'd6, 0);
    tick(3);
    check("R12 irq after end-of-service", 32'(irq), 1);
    rd(3'd5, d); check("R10 R11 end only", d, 2);
    allow = c0 + 8;
    tick(20);
    wr(3'd6, 0);

    // R10 enable bits gate status
    c0 = ncap; allow = c0 + 3;
    start(8'h40, 3, 32'h4, 32'(8 | 2));
    wait_cap(c0 + 3); tick(10);
    rd(3'd5, d); check("R10 half disabled", d, 2);
    wr(3'd6, 0);

    // R7 R8 R9 auto-restart, mask pause, mid-run register writes
    lat = 2; c0 = ncap; allow = c0 + 6;
    start(8'h20, 4, 32'h0, 32'((3 << 3) | 4 | 2));
    tick(80);
    check("R7 wrap frame 0", {capl[(c0 + 4) % 512], capr[(c0 + 4) % 512]}, exp_play(8'h20, 3));
    check("R7 wrap frame 1", {capl[(c0 + 5) % 512], capr[(c0 + 5) % 512]}, exp_play(8'h21, 3));
    rd(3'd2, d); check("R1 cur readable mid-run", d, 32'h23);
    wr(3'd4, 32'h1);
    allow = c0 + 20;
    tick(40);
    check("R8 masked: held frame only", 32'(ncap), 32'(c0 + 7));
    wr(3'd0, 32'h60);
    wr(3'd1, 32'd9);
    tick(10);
    rd(3'd2, d); check("R9 cur unmoved by writes", d, 32'h23);
    check("R8 still paused", 32'(ncap), 32'(c0 + 7));
    allow = c0 + 9;
    wr(3'd4, 32'h0);
    tick(60);
    check("R8 resume at frame 3", {capl[(c0 + 7) % 512], capr[(c0 + 7) % 512]}, exp_play(8'h23, 3));
    check("R9 reload uses new start", {capl[(c0 + 8) % 512], capr[(c0 + 8) % 512]}, exp_play(8'h60, 3));
    wr(3'd3, 32'h0);
    allow = c0 + 10;
    tick(20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule